// File: doc/BRIEF.md
# Hop Tag Stripper with Per-Packet Switch Controls

This block sits at the input of a bufferless self-routing switch node. Packets arrive one at a time as a serial stream, one bit per clock, framed by a valid flag. The front of each packet holds a stack of per-hop tags. The tag at the top of the stack belongs to this node. The block consumes that tag and the guard bit after it. It then passes every later bit on unchanged after a fixed delay: the tags for downstream hops come first, then the payload.

The node makes no address lookup and matches no header. The routing bits of the consumed tag drive the 1x2 stages of the switch fabric directly as level controls. Each control holds for as long as the packet lasts and drops between packets. Packet boundaries come only from the valid flag itself, so no packet-rate reference is needed. A one-cycle start marker is produced for each packet. A packet too short to carry all of its routing bits raises an error pulse in place of any control.

Top module: `tag_strip_router`

## Requirements
- R1: `pkt_start` goes high for exactly one cycle, in the cycle after the first bit of a packet is sampled. A first bit is a sampled cycle with `in_valid` high that follows a sampled cycle with it low. There is exactly one such pulse per packet.
- R2: The leading tag has a fixed bit layout, counted from packet bit 0. Bits 0 and 1 are preamble. Bits 2, 3 and 4 are routing bits. Bit 5 is the guard. Bits 0 to 5 are never forwarded.
- R3: `route_ctrl[k]` takes the value of packet bit 2+k, for k = 0, 1, 2. All three controls update together in the cycle after bit 4 is sampled. They stay low before that point.
- R4: While `in_valid` stays high after bit 4, `route_ctrl` holds its value.
- R5: `route_ctrl` returns to all zeros in the cycle after the first sampled cycle with `in_valid` low.
- R6: Every packet bit at index 6 or higher appears on `fwd_bit` with `fwd_valid` high exactly 6 clock cycles after it was sampled. Bits keep their order and value.
- R7: `fwd_valid` is low at all other times. A packet of 6 bits or fewer forwards nothing.
- R8: A packet of fewer than 5 bits never asserts `route_ctrl`. It raises `short_err` for one cycle, in the cycle after `in_valid` is first sampled low.
- R9: While reset is active, and until the first packet, `pkt_start`, `fwd_valid`, `fwd_bit`, `route_ctrl` and `short_err` are low.
- R10: A packet of exactly 5 bits raises no error. It asserts its controls for one cycle only, then releases them per R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| in_valid | input | 1 | High while a packet bit is present; low for at least one cycle between packets |
| in_bit | input | 1 | Serial packet bit |
| pkt_start | output | 1 | One-cycle marker per packet |
| fwd_valid | output | 1 | High while a forwarded bit is on `fwd_bit` |
| fwd_bit | output | 1 | Forwarded stream: later tags and payload |
| route_ctrl | output | 3 | Per-packet level controls, one per routing bit |
| short_err | output | 1 | One-cycle pulse for a packet that ended before its last routing bit |

## Verification
A wrong bit index inside the block is visible on two outputs within one packet. The controls would take a preamble or guard bit as a routing bit from the cycle after bit 4. The forwarded stream would gain or lose a bit at its head, 6 cycles after packet bit 6. A control register that fails to clear or to hold shows up one cycle after `in_valid` falls, or partway through a long packet. A length test that is off by one shows up at the 4, 5, 6 and 7 bit packet lengths, either as a missing or extra error pulse or as a forwarded bit that should not exist. The scoreboard therefore runs packets at each of those lengths, as well as full-length packets with all-zero, all-one and mixed routing bits.

// File: rtl/tag_strip_pkg.sv
package tag_strip_pkg;
  // default geometry of one hop tag
  localparam int unsigned DEF_PRE_BITS   = 2;
  localparam int unsigned DEF_ROUTE_BITS = 3;
  localparam int unsigned DEF_GUARD_BITS = 1;
endpackage

// File: rtl/tag_pkt_track.sv
module tag_pkt_track #(
  parameter int unsigned STRIP   = 6,
  parameter int unsigned RT_LAST = 4,
  parameter int unsigned CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic [CW-1:0] idx,
  output logic          start_pulse,
  output logic          short_pulse
);
  localparam logic [CW-1:0] IDX_SAT  = CW'(STRIP);
  localparam logic [CW-1:0] IDX_LAST = CW'(RT_LAST);

  logic          prev_v_q, prev_v_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          start_q, start_d;
  logic          short_q, short_d;

  always_comb begin
    prev_v_d = in_valid;
    if (!in_valid)             cnt_d = '0;
    else if (cnt_q == IDX_SAT) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
    start_d = in_valid & ~prev_v_q;
    short_d = ~in_valid & prev_v_q & (cnt_q <= IDX_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_v_q <= 1'b0;
      cnt_q    <= '0;
      start_q  <= 1'b0;
      short_q  <= 1'b0;
    end else begin
      prev_v_q <= prev_v_d;
      cnt_q    <= cnt_d;
      start_q  <= start_d;
      short_q  <= short_d;
    end
  end

  assign idx         = cnt_q;
  assign start_pulse = start_q;
  assign short_pulse = short_q;
endmodule

// File: rtl/tag_route_cap.sv
module tag_route_cap #(
  parameter int unsigned RT_FIRST = 2,
  parameter int unsigned RT_BITS  = 3,
  parameter int unsigned CW       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_bit,
  input  logic [CW-1:0]      idx,
  output logic [RT_BITS-1:0] ctrl
);
  localparam logic [CW-1:0] IDX_LAST = CW'(RT_FIRST + RT_BITS - 1);

  logic [RT_BITS-2:0] shd_q, shd_d;
  logic [RT_BITS-1:0] ctrl_q, ctrl_d;

  always_comb begin
    shd_d = shd_q;
    for (int k = 0; k < int'(RT_BITS) - 1; k++) begin
      if (in_valid && (idx == CW'(RT_FIRST + k))) shd_d[k] = in_bit;
    end
    if (!in_valid)               ctrl_d = '0;
    else if (idx == IDX_LAST)    ctrl_d = {in_bit, shd_q};
    else                         ctrl_d = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= '0;
      ctrl_q <= '0;
    end else begin
      shd_q  <= shd_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/tag_fwd_delay.sv
module tag_fwd_delay #(
  parameter int unsigned DEPTH = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit
);
  logic [DEPTH-1:0] v_q, v_d;
  logic [DEPTH-1:0] b_q, b_d;

  always_comb begin
    v_d = {v_q[DEPTH-2:0], take};
    b_d = {b_q[DEPTH-2:0], in_bit & take};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      b_q <= '0;
    end else begin
      v_q <= v_d;
      b_q <= b_d;
    end
  end

  assign out_valid = v_q[DEPTH-1];
  assign out_bit   = b_q[DEPTH-1];
endmodule

// File: rtl/tag_strip_router.sv
module tag_strip_router #(
  parameter int unsigned PRE_BITS   = tag_strip_pkg::DEF_PRE_BITS,
  parameter int unsigned ROUTE_BITS = tag_strip_pkg::DEF_ROUTE_BITS,
  parameter int unsigned GUARD_BITS = tag_strip_pkg::DEF_GUARD_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_bit,
  output logic                  pkt_start,
  output logic                  fwd_valid,
  output logic                  fwd_bit,
  output logic [ROUTE_BITS-1:0] route_ctrl,
  output logic                  short_err
);
  localparam int unsigned RT_FIRST = PRE_BITS;
  localparam int unsigned RT_LAST  = PRE_BITS + ROUTE_BITS - 1;
  localparam int unsigned STRIP    = PRE_BITS + ROUTE_BITS + GUARD_BITS;
  localparam int unsigned CW       = $clog2(STRIP + 1);
  localparam logic [CW-1:0] IDX_SAT = CW'(STRIP);

  // reset asserted asynchronously, released on the clock
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [CW-1:0] idx;
  logic          take;

  tag_pkt_track #(.STRIP(STRIP), .RT_LAST(RT_LAST), .CW(CW)) u_track (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid),
    .idx(idx), .start_pulse(pkt_start), .short_pulse(short_err)
  );

  tag_route_cap #(.RT_FIRST(RT_FIRST), .RT_BITS(ROUTE_BITS), .CW(CW)) u_cap (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_bit(in_bit),
    .idx(idx), .ctrl(route_ctrl)
  );

  assign take = in_valid & (idx == IDX_SAT);

  tag_fwd_delay #(.DEPTH(STRIP)) u_dly (
    .clk(clk), .rst_n(rst_core_n), .take(take), .in_bit(in_bit),
    .out_valid(fwd_valid), .out_bit(fwd_bit)
  );
endmodule

// File: rtl/tag_strip_router_chk.sv
module tag_strip_router_chk #(
  parameter int unsigned RT_BITS = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               pkt_start,
  input logic [RT_BITS-1:0] route_ctrl,
  input logic               short_err
);
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> !pkt_start); // R1

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && route_ctrl != '0) |=> $stable(route_ctrl)); // R4

  AST_CTRL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> route_ctrl == '0); // R5

  AST_SHORT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> (!$past(in_valid) && $past(in_valid, 2))); // R8

  AST_SHORT_NO_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |-> route_ctrl == '0); // R8
endmodule

bind tag_strip_router tag_strip_router_chk #(.RT_BITS(ROUTE_BITS)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .pkt_start(pkt_start),
  .route_ctrl(route_ctrl), .short_err(short_err)
);

// File: tb/tag_strip_router_tb.sv
module tag_strip_router_tb;
  localparam time TCK = 8ns;   // 125 MHz
  localparam time FWD_LAT = 45ns; // drive at negedge, seen 6 edges later + 1ns

  typedef struct { logic [2:0] ctrl; logic st; logic er; string tag; } rec_t;
  typedef struct { logic b; time t; } fb_t;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_bit;
  logic pkt_start, fwd_valid, fwd_bit, short_err;
  logic [2:0] route_ctrl;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  rec_t rq[$];
  fb_t  fq[$];

  always #(TCK/2) clk = ~clk;

  tag_strip_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .pkt_start(pkt_start), .fwd_valid(fwd_valid), .fwd_bit(fwd_bit),
    .route_ctrl(route_ctrl), .short_err(short_err)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_rec(input logic [2:0] c, input logic s, input logic e, input string t);
    rec_t r;
    r.ctrl = c; r.st = s; r.er = e; r.tag = t;
    rq.push_back(r);
  endtask

  // driver: sends one packet, then gap idle cycles
  task automatic send_pkt(input logic [2:0] rt, input int len, input int gap);
    for (int j = 0; j < len; j++) begin
      logic b;
      string t;
      @(negedge clk);
      case (j)
        0: b = 1'b1;
        1: b = 1'b0;
        2, 3, 4: b = rt[j-2];
        5: b = 1'b0;
        default: b = 1'($urandom);
      endcase
      in_valid = 1'b1;
      in_bit   = b;
      if (len < 5)       t = "R8";
      else if (len == 5) t = "R10";
      else if (j > 4)    t = "R4";
      else               t = "R3";
      push_rec((j >= 4) ? rt : 3'b000, (j == 0), 1'b0, t);
      if (j >= 6) begin
        fb_t f;
        f.b = b; f.t = $time;
        fq.push_back(f);
      end
    end
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_bit   = 1'($urandom);
      if (g == 0) push_rec(3'b000, 1'b0, (len < 5), (len < 5) ? "R8" : "R5");
      else        push_rec(3'b000, 1'b0, 1'b0, "R7");
    end
  endtask

  // monitor: compares one record per cycle and the forwarded stream
  initial begin
    forever begin
      @(posedge clk);
      #1ns;
      if (rq.size() > 0) begin
        rec_t r;
        r = rq.pop_front();
        chk("R1", {7'd0, pkt_start}, {7'd0, r.st});
        chk(r.tag, {5'd0, route_ctrl}, {5'd0, r.ctrl});
        chk("R8", {7'd0, short_err}, {7'd0, r.er});
      end
      while (fq.size() > 0 && fq[0].t + FWD_LAT < $time) begin
        checks++; errors++;
        $display("FAIL R6 missing forwarded bit actual=none expected=%0b", fq[0].b);
        void'(fq.pop_front());
      end
      if (fwd_valid) begin
        if (fq.size() == 0 || fq[0].t + FWD_LAT != $time) begin
          checks++; errors++;
          $display("FAIL R7 unexpected fwd_valid actual=1 expected=0 at %0t", $time);
        end else begin
          chk("R2/R6", {7'd0, fwd_bit}, {7'd0, fq[0].b});
          void'(fq.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs quiet while in reset
    chk("R9", {fwd_valid, fwd_bit, pkt_start, short_err, 1'b0, route_ctrl}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", {fwd_valid, fwd_bit, pkt_start, short_err, 1'b0, route_ctrl}, 8'h00);

    send_pkt(3'b101, 52, 2);  // two tags plus 40 payload bits
    send_pkt(3'b000, 52, 1);
    send_pkt(3'b111, 52, 3);
    send_pkt(3'b010, 6, 2);   // nothing to forward
    send_pkt(3'b110, 7, 1);   // one forwarded bit
    send_pkt(3'b011, 5, 2);   // exactly enough for routing
    send_pkt(3'b111, 4, 2);   // short
    send_pkt(3'b111, 3, 1);   // short
    send_pkt(3'b001, 1, 1);   // short
    send_pkt(3'b100, 20, 1);
    send_pkt(3'b011, 52, 10);
    repeat (12) @(negedge clk);
    chk("R6", 8'(fq.size()), 8'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule